// File: doc/BRIEF.md
# Serial Debug Port Command Shifter

This block is the target end of a clocked serial debug link between an external debug tool and a CPU core. On every rising edge of the debug clock it takes one bit from the tool and returns one bit. Each inbound frame has a start bit, a mode bit, a control bit and a 32-bit payload. The block decodes the frame as a CPU instruction, a CPU data word, a write of the 7-bit trap-enable register, or a port command. The outbound frame runs alongside the inbound one. It opens with a ready bit of 0, then carries a 2-bit status and a 32-bit payload.

On the core side there are two streams. The decoded instruction or data word goes to the core on a valid/ready stream. A word that the core has placed in the port's data register comes in on a second valid/ready stream. Back-pressure on both streams uses the serial ready bit. While a decoded word waits for `xfer_ready`, the port does not signal ready and ignores start bits. While a captured core word waits to be shifted out, `dpdr_ready` stays low. The core states, through `cpu_req` and `cpu_req_data`, whether it is waiting for a word from the port and of which kind. The port uses this to detect instruction/data ordering errors.

Top module: `dbg_serial_port`

## Requirements
- R1: When no frame is in progress, `sdo` is 0 (the ready bit) exactly when `cpu_req` is 1 and no decoded word is pending on `xfer_valid`. Otherwise `sdo` is 1.
- R2: A 1 on `sdi` while the port is not ready does not start a frame. A full frame's worth of bits sent then produces no output change, and `sdo` stays 1.
- R3: Both directions shift MSB first. Inbound: start bit 1, then mode, control and payload bits 31..0. Outbound, on the edges that take in mode, control and payload: status bit 1, status bit 0, then payload bits 31..0. The outbound payload is 0 for every status except valid data.
- R4: A frame with mode 0 whose control bit matches `cpu_req_data` (latched at the start bit) raises `xfer_valid`. The frame also sets `xfer_is_data` to the control bit (0 = instruction, 1 = data) and `xfer_word` to the payload. All three hold steady until a cycle with `xfer_ready` high. The word is visible on the edge that takes in the last payload bit.
- R5: A mode-0 frame whose control bit differs from `cpu_req_data` is not delivered. The next outbound frame carries status 01 (sequence error). The error flag clears once it has been sent.
- R6: A frame with mode 1 and control 0 loads payload bits 31..25 into `trap_en`. No other frame changes `trap_en`.
- R7: A frame with mode 1 and control 1 is a command. The code is in payload bits 31..25. Code 0x01 pulses `bkpt_negate` for one cycle. Code 0x02 pulses `core_reset` for one cycle. Code 0x03 sets `fast_dl` and code 0x04 clears it. Code 0x1F (no operation) and every other code have no effect.
- R8: A core word accepted on `dpdr_valid`/`dpdr_ready` is sent in the next outbound frame with status 00. This has the highest priority, even over a pending sequence error or a high `cpu_irq`. `dpdr_ready` is low from acceptance until that frame starts.
- R9: Without valid data, the outbound status is 01 if a sequence error is pending, else 10 if `cpu_irq` is high, else 11 (null).
- R10: After reset, `trap_en` is 0, `fast_dl` is 0, `xfer_valid` is 0, `dpdr_ready` is 1 and no sequence error is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debug shift clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdi | input | 1 | Serial data from the tool |
| sdo | output | 1 | Serial data to the tool (ready bit, status, payload) |
| cpu_req | input | 1 | Core is waiting for a word from the port |
| cpu_req_data | input | 1 | Kind the core expects: 1 data, 0 instruction |
| cpu_irq | input | 1 | Interrupt recognised by the core |
| xfer_valid | output | 1 | Decoded instruction/data word available |
| xfer_ready | input | 1 | Core takes the decoded word |
| xfer_is_data | output | 1 | Decoded word is data (1) or instruction (0) |
| xfer_word | output | 32 | Decoded payload |
| dpdr_valid | input | 1 | Core offers a word for the tool |
| dpdr_ready | output | 1 | Port can accept a core word |
| dpdr_word | input | 32 | Core word for the tool |
| trap_en | output | 7 | Trap-enable register |
| bkpt_negate | output | 1 | One-cycle request to negate breakpoint requests |
| core_reset | output | 1 | One-cycle core reset request |
| fast_dl | output | 1 | Fast-download mode active |

## Verification
The hardest state to reach is the one where valid data, a pending sequence error and a raised interrupt all compete for the same outbound frame. The serial protocol rarely lets these coexist. The bench gets there in three steps. It first sends a data frame while the core expects an instruction, which leaves an error pending. It then pushes a core word into the data register and holds `cpu_irq` high. Finally it sends no-op frames one after another and checks that the statuses come out as 00, then 01, then 10, then 11. A second hard case is a frame sent while the port is not ready: the bench clocks a complete frame under `cpu_req` low, then shows with a normal frame that nothing from it was decoded.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;
  typedef enum logic [1:0] {
    ST_DATA   = 2'b00,
    ST_SEQERR = 2'b01,
    ST_IRQ    = 2'b10,
    ST_NULL   = 2'b11
  } dbgp_status_e;

  localparam int unsigned CODE_W = 7;
  localparam logic [CODE_W-1:0] CMD_NEG_BKPT = 7'h01;
  localparam logic [CODE_W-1:0] CMD_CORE_RST = 7'h02;
  localparam logic [CODE_W-1:0] CMD_FDL_ON   = 7'h03;
  localparam logic [CODE_W-1:0] CMD_FDL_OFF  = 7'h04;
  localparam logic [CODE_W-1:0] CMD_NOP      = 7'h1F;
endpackage

// File: rtl/dbgp_shifter.sv
module dbgp_shifter #(
  parameter int unsigned FRAME_W = 34
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sdi,
  input  logic               port_rdy,
  input  logic [FRAME_W-1:0] load_word,
  output logic               sdo,
  output logic               start,
  output logic               frame_done,
  output logic [FRAME_W-1:0] frame_word
);
  localparam int unsigned CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic               busy_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-2:0] in_q;
  logic [FRAME_W-1:0] out_q;

  // a start bit is only honoured while the ready bit is being driven
  assign start      = !busy_q && port_rdy && sdi;
  assign frame_done = busy_q && (cnt_q == LAST);
  assign frame_word = {in_q, sdi};
  assign sdo        = busy_q ? out_q[FRAME_W-1] : !port_rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      in_q   <= '0;
      out_q  <= '1;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      out_q  <= load_word;
    end else if (busy_q) begin
      in_q  <= frame_word[FRAME_W-2:0];
      out_q <= {out_q[FRAME_W-2:0], 1'b1};
      cnt_q <= cnt_q + 1'b1;
      if (frame_done) busy_q <= 1'b0;
    end
  end

  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_q && (cnt_q == '0));
endmodule

// File: rtl/dbgp_status.sv
module dbgp_status
  import dbgp_pkg::*;
#(
  parameter int unsigned PAYLOAD_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 seq_set,
  input  logic                 irq,
  input  logic                 dpdr_valid,
  input  logic [PAYLOAD_W-1:0] dpdr_word,
  output logic                 dpdr_ready,
  output logic [PAYLOAD_W+1:0] load_word
);
  logic                 hold_v_q;
  logic [PAYLOAD_W-1:0] hold_w_q;
  logic                 seq_q;
  dbgp_status_e         st;

  assign dpdr_ready = !hold_v_q;

  // fixed ranking: captured data, ordering error, interrupt, null
  always_comb begin
    if (hold_v_q)   st = ST_DATA;
    else if (seq_q) st = ST_SEQERR;
    else if (irq)   st = ST_IRQ;
    else            st = ST_NULL;
    load_word = {st, hold_v_q ? hold_w_q : {PAYLOAD_W{1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v_q <= 1'b0;
      hold_w_q <= '0;
      seq_q    <= 1'b0;
    end else begin
      if (start && hold_v_q) hold_v_q <= 1'b0;
      else if (dpdr_valid && !hold_v_q) begin
        hold_v_q <= 1'b1;
        hold_w_q <= dpdr_word;
      end
      if (seq_set) seq_q <= 1'b1;
      else if (start && !hold_v_q && seq_q) seq_q <= 1'b0;
    end
  end

  p_data_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start && hold_v_q |=> !hold_v_q);
  p_seq_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start && !hold_v_q && seq_q |=> !seq_q);
endmodule

// File: rtl/dbgp_decode.sv
module dbgp_decode
  import dbgp_pkg::*;
#(
  parameter int unsigned PAYLOAD_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 exp_data,
  input  logic                 frame_done,
  input  logic [PAYLOAD_W+1:0] frame_word,
  input  logic                 xfer_ready,
  output logic                 xfer_valid,
  output logic                 xfer_is_data,
  output logic [PAYLOAD_W-1:0] xfer_word,
  output logic                 seq_set,
  output logic [CODE_W-1:0]    trap_en,
  output logic                 bkpt_negate,
  output logic                 core_reset,
  output logic                 fast_dl
);
  logic                 mode, ctrl;
  logic [PAYLOAD_W-1:0] payload;
  logic [CODE_W-1:0]    code;
  logic                 exp_q;

  assign mode    = frame_word[PAYLOAD_W+1];
  assign ctrl    = frame_word[PAYLOAD_W];
  assign payload = frame_word[PAYLOAD_W-1:0];
  assign code    = payload[PAYLOAD_W-1 -: CODE_W];
  assign seq_set = frame_done && !mode && (ctrl != exp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q        <= 1'b0;
      xfer_valid   <= 1'b0;
      xfer_is_data <= 1'b0;
      xfer_word    <= '0;
      trap_en      <= '0;
      bkpt_negate  <= 1'b0;
      core_reset   <= 1'b0;
      fast_dl      <= 1'b0;
    end else begin
      bkpt_negate <= 1'b0;
      core_reset  <= 1'b0;
      if (start) exp_q <= exp_data;
      if (xfer_valid && xfer_ready) xfer_valid <= 1'b0;
      if (frame_done) begin
        unique case ({mode, ctrl})
          2'b00, 2'b01: if (ctrl == exp_q) begin
            xfer_valid   <= 1'b1;
            xfer_is_data <= ctrl;
            xfer_word    <= payload;
          end
          2'b10: trap_en <= code;
          default: begin
            if (code == CMD_NEG_BKPT) bkpt_negate <= 1'b1;
            if (code == CMD_CORE_RST) core_reset  <= 1'b1;
            if (code == CMD_FDL_ON)   fast_dl     <= 1'b1;
            if (code == CMD_FDL_OFF)  fast_dl     <= 1'b0;
          end
        endcase
      end
    end
  end

  p_xfer_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_word) && $stable(xfer_is_data));
  p_rst_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    core_reset |=> !core_reset);
  p_neg_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bkpt_negate |=> !bkpt_negate);
  p_trap_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(trap_en));
endmodule

// File: rtl/dbg_serial_port.sv
module dbg_serial_port
  import dbgp_pkg::*;
#(
  parameter int unsigned PAYLOAD_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sdi,
  output logic                 sdo,
  input  logic                 cpu_req,
  input  logic                 cpu_req_data,
  input  logic                 cpu_irq,
  output logic                 xfer_valid,
  input  logic                 xfer_ready,
  output logic                 xfer_is_data,
  output logic [PAYLOAD_W-1:0] xfer_word,
  input  logic                 dpdr_valid,
  output logic                 dpdr_ready,
  input  logic [PAYLOAD_W-1:0] dpdr_word,
  output logic [CODE_W-1:0]    trap_en,
  output logic                 bkpt_negate,
  output logic                 core_reset,
  output logic                 fast_dl
);
  localparam int unsigned FRAME_W = PAYLOAD_W + 2;

  logic               port_rdy, start, frame_done, seq_set;
  logic [FRAME_W-1:0] load_word, frame_word;

  // back-pressure: no ready bit while a decoded word waits for the core
  assign port_rdy = cpu_req && !xfer_valid;

  dbgp_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sdi(sdi), .port_rdy(port_rdy),
    .load_word(load_word), .sdo(sdo), .start(start),
    .frame_done(frame_done), .frame_word(frame_word)
  );

  dbgp_status #(.PAYLOAD_W(PAYLOAD_W)) u_status (
    .clk(clk), .rst_n(rst_n), .start(start), .seq_set(seq_set),
    .irq(cpu_irq), .dpdr_valid(dpdr_valid), .dpdr_word(dpdr_word),
    .dpdr_ready(dpdr_ready), .load_word(load_word)
  );

  dbgp_decode #(.PAYLOAD_W(PAYLOAD_W)) u_decode (
    .clk(clk), .rst_n(rst_n), .start(start), .exp_data(cpu_req_data),
    .frame_done(frame_done), .frame_word(frame_word),
    .xfer_ready(xfer_ready), .xfer_valid(xfer_valid),
    .xfer_is_data(xfer_is_data), .xfer_word(xfer_word),
    .seq_set(seq_set), .trap_en(trap_en), .bkpt_negate(bkpt_negate),
    .core_reset(core_reset), .fast_dl(fast_dl)
  );
endmodule

// File: tb/dbg_serial_port_tb_top.sv
`timescale 1ns/1ps
module dbg_serial_port_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, sdi = 1'b0;
  logic cpu_req = 1'b0, cpu_req_data = 1'b0, cpu_irq = 1'b0;
  logic xfer_ready = 1'b0, dpdr_valid = 1'b0;
  logic [31:0] dpdr_word = '0;
  logic sdo, xfer_valid, xfer_is_data, dpdr_ready, bkpt_negate, core_reset, fast_dl;
  logic [31:0] xfer_word;
  logic [6:0] trap_en;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  dbg_serial_port dut_i (
    .clk(clk), .rst_n(rst_n), .sdi(sdi), .sdo(sdo), .cpu_req(cpu_req),
    .cpu_req_data(cpu_req_data), .cpu_irq(cpu_irq), .xfer_valid(xfer_valid),
    .xfer_ready(xfer_ready), .xfer_is_data(xfer_is_data), .xfer_word(xfer_word),
    .dpdr_valid(dpdr_valid), .dpdr_ready(dpdr_ready), .dpdr_word(dpdr_word),
    .trap_en(trap_en), .bkpt_negate(bkpt_negate), .core_reset(core_reset),
    .fast_dl(fast_dl)
  );

  // row: {req_data, irq, mode, ctrl, payload[31:0], exp_status[1:0], delivered}
  localparam logic [38:0] VEC [0:7] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 32'h12345678, 2'b11, 1'b1},
    {1'b1, 1'b0, 1'b0, 1'b1, 32'hCAFEF00D, 2'b11, 1'b1},
    {1'b0, 1'b0, 1'b0, 1'b1, 32'h0BADBEEF, 2'b11, 1'b0},
    {1'b0, 1'b1, 1'b0, 1'b0, 32'h00000001, 2'b01, 1'b1},
    {1'b0, 1'b1, 1'b0, 1'b0, 32'h80000000, 2'b10, 1'b1},
    {1'b1, 1'b0, 1'b0, 1'b0, 32'hFFFFFFFF, 2'b11, 1'b0},
    {1'b1, 1'b0, 1'b1, 1'b1, {7'h1F, 25'h0}, 2'b01, 1'b0},
    {1'b1, 1'b0, 1'b1, 1'b1, {7'h1F, 25'h0}, 2'b11, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the last payload edge
  task automatic send_frame(input logic m, input logic c, input logic [31:0] pl,
                            output logic [1:0] st, output logic [31:0] opl);
    logic [33:0] fr, rx;
    int w = 0;
    fr = {m, c, pl};
    rx = '1;
    while (sdo !== 1'b0 && w < 50) begin @(negedge clk); w++; end
    if (w >= 50) chk(1'b0, "R1 ready bit never seen", sdo, 0);
    sdi = 1'b1;
    @(negedge clk);
    for (int i = 33; i >= 0; i--) begin
      rx[i] = sdo;
      sdi = fr[i];
      @(negedge clk);
    end
    sdi = 1'b0;
    st = rx[33:32];
    opl = rx[31:0];
  endtask

  task automatic nop_expect(input logic [1:0] est, input logic [31:0] epl, input string req);
    logic [1:0] st;
    logic [31:0] pl;
    send_frame(1'b1, 1'b1, {7'h1F, 25'h0}, st, pl);
    chk(st == est, req, st, est);
    chk(pl == epl, req, pl, epl);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [1:0] st;
    logic [31:0] pl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state, R1 not ready while cpu_req low
    chk(sdo == 1'b1, "R1 idle not ready", sdo, 1);
    chk(trap_en == 7'h0, "R10 trap reset", trap_en, 0);
    chk(fast_dl == 1'b0, "R10 fast_dl reset", fast_dl, 0);
    chk(xfer_valid == 1'b0, "R10 xfer_valid reset", xfer_valid, 0);
    chk(dpdr_ready == 1'b1, "R10 dpdr_ready reset", dpdr_ready, 1);

    // R2: a whole frame under not-ready is ignored
    begin
      logic [34:0] junk = {1'b1, 1'b1, 1'b0, 7'h55, 25'h0};
      logic stayed = 1'b1;
      for (int i = 34; i >= 0; i--) begin
        sdi = junk[i];
        @(negedge clk);
        if (sdo !== 1'b1) stayed = 1'b0;
      end
      sdi = 1'b0;
      chk(stayed, "R2 sdo stayed high", stayed, 1);
      chk(trap_en == 7'h0, "R2 trap untouched", trap_en, 0);
    end
    cpu_req = 1'b1;
    #1;
    chk(sdo == 1'b0, "R1 ready bit low", sdo, 0);
    @(negedge clk);

    // table walk: R3 R4 R5 R9
    for (int k = 0; k < 8; k++) begin
      logic [38:0] v = VEC[k];
      cpu_req_data = v[38];
      cpu_irq = v[37];
      send_frame(v[36], v[35], v[34:3], st, pl);
      chk(st == v[2:1], $sformatf("R5 R9 row %0d status", k), st, v[2:1]);
      chk(pl == 32'h0, $sformatf("R3 row %0d payload zero", k), pl, 0);
      if (v[0]) begin
        chk(xfer_valid == 1'b1, $sformatf("R4 row %0d valid", k), xfer_valid, 1);
        chk(xfer_word == v[34:3], $sformatf("R4 row %0d word", k), xfer_word, v[34:3]);
        chk(xfer_is_data == v[35], $sformatf("R4 row %0d kind", k), xfer_is_data, v[35]);
        @(negedge clk);
        chk(sdo == 1'b1 && xfer_valid == 1'b1, $sformatf("R1 R4 row %0d held", k), sdo, 1);
        xfer_ready = 1'b1;
        @(negedge clk);
        xfer_ready = 1'b0;
        chk(xfer_valid == 1'b0, $sformatf("R4 row %0d taken", k), xfer_valid, 0);
        chk(sdo == 1'b0, $sformatf("R1 row %0d ready again", k), sdo, 0);
      end else begin
        chk(xfer_valid == 1'b0, $sformatf("R5 row %0d not delivered", k), xfer_valid, 0);
      end
    end
    cpu_irq = 1'b0;

    // R6 trap writes
    send_frame(1'b1, 1'b0, {7'h55, 25'h1FFFFFF}, st, pl);
    chk(trap_en == 7'h55, "R6 trap write", trap_en, 7'h55);
    send_frame(1'b1, 1'b1, {7'h2A, 25'h0}, st, pl);
    chk(trap_en == 7'h55, "R6 R7 reserved code keeps trap", trap_en, 7'h55);
    send_frame(1'b1, 1'b0, {7'h7F, 25'h0}, st, pl);
    chk(trap_en == 7'h7F, "R6 trap all ones", trap_en, 7'h7F);

    // R7 commands
    send_frame(1'b1, 1'b1, {7'h01, 25'h0}, st, pl);
    chk(bkpt_negate == 1'b1 && core_reset == 1'b0, "R7 negate pulse", bkpt_negate, 1);
    @(negedge clk);
    chk(bkpt_negate == 1'b0, "R7 negate one cycle", bkpt_negate, 0);
    send_frame(1'b1, 1'b1, {7'h02, 25'h0}, st, pl);
    chk(core_reset == 1'b1 && bkpt_negate == 1'b0, "R7 reset pulse", core_reset, 1);
    @(negedge clk);
    chk(core_reset == 1'b0, "R7 reset one cycle", core_reset, 0);
    send_frame(1'b1, 1'b1, {7'h03, 25'h0}, st, pl);
    chk(fast_dl == 1'b1, "R7 fast on", fast_dl, 1);
    send_frame(1'b1, 1'b1, {7'h7F, 25'h0}, st, pl);
    chk(fast_dl == 1'b1 && core_reset == 1'b0 && bkpt_negate == 1'b0, "R7 reserved ignored", fast_dl, 1);
    send_frame(1'b1, 1'b1, {7'h1F, 25'h0}, st, pl);
    chk(fast_dl == 1'b1 && trap_en == 7'h7F, "R7 nop no effect", fast_dl, 1);
    send_frame(1'b1, 1'b1, {7'h04, 25'h0}, st, pl);
    chk(fast_dl == 1'b0, "R7 fast off", fast_dl, 0);

    // R8 R9: data outranks pending error and interrupt
    cpu_req_data = 1'b0;
    send_frame(1'b0, 1'b1, 32'h13572468, st, pl);
    chk(xfer_valid == 1'b0, "R5 mismatch dropped", xfer_valid, 0);
    chk(dpdr_ready == 1'b1, "R8 ready before push", dpdr_ready, 1);
    dpdr_valid = 1'b1;
    dpdr_word = 32'hA5A55A5A;
    @(negedge clk);
    dpdr_valid = 1'b0;
    chk(dpdr_ready == 1'b0, "R8 ready low while held", dpdr_ready, 0);
    cpu_irq = 1'b1;
    nop_expect(2'b00, 32'hA5A55A5A, "R8 valid data first");
    chk(dpdr_ready == 1'b1, "R8 ready after send", dpdr_ready, 1);
    nop_expect(2'b01, 32'h0, "R9 seq error next");
    nop_expect(2'b10, 32'h0, "R9 interrupt next");
    cpu_irq = 1'b0;
    nop_expect(2'b11, 32'h0, "R9 null last");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule